// File: doc/BRIEF.md
# Burst Request Issuer for a Stallable Memory Port

This block sits on the master side of a memory controller's local port. It takes one transaction command at a time (direction, start word address and burst length) over a valid/ready handshake. From each command it produces a read or write request with the start address and the burst length, plus a burst-begin strobe. The slave may stall the request by holding its ready input low.

The strobe and the request behave differently during a stall. The burst-begin strobe is a single-cycle marker for each burst, and it is never stretched by a stall. The request lines, the address and the burst length stay frozen until the slave is ready again. A write burst runs until the slave has taken the commanded number of beats. A read burst is handed over in one accepted cycle. The outgoing word address is also split into row, bank and column fields for a downstream monitor. The column is rebuilt at memory-bus granularity, so its two lowest bits are zero.

Top module: `burst_req_issuer`

## Requirements
- R1: After reset, no read or write request and no burst-begin strobe is driven, and the command input is ready.
- R2: A command accepted on a clock edge (cmd_valid and cmd_ready both high) appears in the very next cycle. That cycle drives req_burstbegin high together with the request selected by cmd_write (1 selects write, 0 selects read), req_addr equal to cmd_addr, and req_burstcount equal to cmd_len. A cmd_len of 0 is issued as a count of 1.
- R3: The burst-begin strobe is high for exactly one cycle per burst, the cycle after acceptance, even when req_ready is low in that cycle.
- R4: While a request is driven and req_ready is low, the request lines, req_addr and req_burstcount keep their values in the next cycle.
- R5: A write burst of count N keeps req_write high until N cycles with req_write and req_ready both high have occurred, and drops it in the cycle after the N-th such cycle unless another command was accepted.
- R6: A read burst ends on the first cycle with req_read and req_ready both high. req_read is low in the following cycle unless another command was accepted in that same cycle.
- R7: cmd_ready is low while a burst is in progress, except in the cycle in which the burst's final beat (write) or its single transfer (read) is accepted. A command taken in that cycle starts its burst-begin in the cycle immediately after.
- R8: The monitor fields split req_addr (width ROW_W+BANK_W+COL_W-2) as follows: the top ROW_W bits form the row; the next BANK_W bits form the bank; the low COL_W-2 bits form column bits [COL_W-1:2]. Column bits [1:0] are zero. With 13/2/10 this gives row = addr[22:10], bank = addr[9:8], col = {addr[7:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | ADDR_W (23) | Start word address |
| cmd_len | input | LEN_W (4) | Burst length in beats, 0 treated as 1 |
| req_ready | input | 1 | Slave can accept the current request |
| req_read | output | 1 | Read request |
| req_write | output | 1 | Write request |
| req_addr | output | ADDR_W (23) | Burst start word address |
| req_burstcount | output | LEN_W (4) | Beats in the current burst |
| req_burstbegin | output | 1 | One-cycle marker at the start of each burst |
| mon_row | output | ROW_W (13) | Row field of req_addr |
| mon_bank | output | BANK_W (2) | Bank field of req_addr |
| mon_col | output | COL_W (10) | Column at memory-bus granularity, low two bits zero |

## Verification
The stall and burst-length properties assume that the slave's ready input is a clean 0 or 1 in every cycle after reset. They also assume that the command fields are only sampled when the valid/ready handshake completes. No further handshake discipline on ready is assumed, since the block must tolerate ready dropping in any cycle, including the burst-begin cycle. The directed scenarios change cmd_valid, cmd_write, cmd_addr, cmd_len and req_ready only just after a rising edge. They deliberately hold a second command valid through an entire stalled burst, so that any acceptance during the burst would show at the ports.

// File: rtl/bri_pkg.sv
package bri_pkg;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } bri_kind_e;

endpackage

// File: rtl/bri_beat_counter.sv
module bri_beat_counter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_count,
    input  logic             beat,
    output logic             last
);

    typedef struct packed {
        logic [LEN_W-1:0] remain;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.remain = load_count - LEN_W'(1);
        end else if (beat && cnt_q.remain != '0) begin
            cnt_d.remain = cnt_q.remain - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q.remain == '0);

endmodule

// File: rtl/bri_addr_split.sv
module bri_addr_split #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W - 2,
    localparam int CLO_W  = COL_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);

    assign row  = addr[ADDR_W-1 -: ROW_W];
    assign bank = addr[CLO_W +: BANK_W];
    assign col  = {addr[CLO_W-1:0], 2'b00};

endmodule

// File: rtl/burst_req_issuer.sv
module burst_req_issuer
    import bri_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int LEN_W  = 4,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              req_ready,
    output logic              req_read,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_burstcount,
    output logic              req_burstbegin,
    output logic [ROW_W-1:0]  mon_row,
    output logic [BANK_W-1:0] mon_bank,
    output logic [COL_W-1:0]  mon_col
);

    typedef struct packed {
        logic              busy;
        bri_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  count;
        logic              strobe;
    } state_t;

    state_t st_d, st_q;

    logic             take;
    logic             finish;
    logic             last_beat;
    logic             wr_beat;
    logic [LEN_W-1:0] eff_len;

    // Zero-length commands are issued as single-beat bursts.
    assign eff_len = (cmd_len == '0) ? LEN_W'(1) : cmd_len;

    assign wr_beat = st_q.busy && (st_q.kind == CMD_WRITE) && req_ready;
    assign finish  = st_q.busy && req_ready
                     && ((st_q.kind == CMD_READ) || last_beat);

    assign cmd_ready = !st_q.busy || finish;
    assign take      = cmd_valid && cmd_ready;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (take) begin
            st_d.busy   = 1'b1;
            st_d.kind   = bri_kind_e'(cmd_write);
            st_d.addr   = cmd_addr;
            st_d.count  = eff_len;
            st_d.strobe = 1'b1;
        end else if (finish) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: CMD_READ, addr: '0,
                      count: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    bri_beat_counter #(
        .LEN_W(LEN_W)
    ) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_count(eff_len),
        .beat      (wr_beat),
        .last      (last_beat)
    );

    assign req_read       = st_q.busy && (st_q.kind == CMD_READ);
    assign req_write      = st_q.busy && (st_q.kind == CMD_WRITE);
    assign req_addr       = st_q.addr;
    assign req_burstcount = st_q.count;
    assign req_burstbegin = st_q.strobe;

    bri_addr_split #(
        .ROW_W (ROW_W),
        .BANK_W(BANK_W),
        .COL_W (COL_W)
    ) u_split (
        .addr(st_q.addr),
        .row (mon_row),
        .bank(mon_bank),
        .col (mon_col)
    );

endmodule

// File: rtl/bri_checker.sv
module bri_checker #(
    parameter int ADDR_W = 23,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              req_ready,
    input logic              req_read,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_burstcount,
    input logic              req_burstbegin
);

    logic             take;
    logic             busy;
    logic [LEN_W:0]   seen;
    logic [LEN_W:0]   beats_q;

    assign take = cmd_valid && cmd_ready;
    assign busy = req_read || req_write;
    assign seen = req_burstbegin ? '0 : beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (req_write && req_ready) begin
            beats_q <= seen + 1'b1;
        end else begin
            beats_q <= seen;
        end
    end

    // R2: acceptance is followed by a strobed request
    assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (req_burstbegin && (req_read || req_write)));

    // R3: strobe only accompanies a request
    assert_strobe_with_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_burstbegin |-> busy);

    // R4 and R3: stall freezes the request and never stretches the strobe
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_ready) |=> ($stable(req_read) && $stable(req_write)
            && $stable(req_addr) && $stable(req_burstcount) && !req_burstbegin));

    // R5: write continues until all beats are taken
    assert_write_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && req_ready && ((seen + 1'b1) < {1'b0, req_burstcount}))
            |=> (req_write && !req_burstbegin));

    // R5: write ends after the final beat
    assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && req_ready && ((seen + 1'b1) == {1'b0, req_burstcount}) && !take)
            |=> !busy);

    // R6: read completes in one accepted cycle
    assert_read_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_read && req_ready && !take) |=> !busy);

    // R7: no command taken while a request is stalled
    assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && busy) |-> req_ready);

endmodule

bind burst_req_issuer bri_checker #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .req_ready     (req_ready),
    .req_read      (req_read),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_burstcount(req_burstcount),
    .req_burstbegin(req_burstbegin)
);

// File: tb/sim_burst_req_issuer.sv
`timescale 1ns/1ps
module sim_burst_req_issuer;

    localparam int ROW_W  = 13;
    localparam int BANK_W = 2;
    localparam int COL_W  = 10;
    localparam int LEN_W  = 4;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_write = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              req_ready = 1'b0;
    logic              req_read;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [LEN_W-1:0]  req_burstcount;
    logic              req_burstbegin;
    logic [ROW_W-1:0]  mon_row;
    logic [BANK_W-1:0] mon_bank;
    logic [COL_W-1:0]  mon_col;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    burst_req_issuer #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .LEN_W(LEN_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .req_ready(req_ready), .req_read(req_read), .req_write(req_write),
        .req_addr(req_addr), .req_burstcount(req_burstcount),
        .req_burstbegin(req_burstbegin),
        .mon_row(mon_row), .mon_bank(mon_bank), .mon_col(mon_col)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // Offer a command and return in the cycle right after it was taken.
    task automatic issue(input logic wr, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] n);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_len   = n;
        #1;
        while (!cmd_ready) begin
            tick();
        end
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 read idle", 32'(req_read), 0);
        chk("R1 write idle", 32'(req_write), 0);
        chk("R1 strobe idle", 32'(req_burstbegin), 0);
        chk("R1 cmd_ready", 32'(cmd_ready), 1);
    endtask

    task automatic t_write_stall;
        logic [ADDR_W-1:0] a = 23'h12_3456;
        issue(1'b1, a, 4'd4);
        chk("R2 strobe", 32'(req_burstbegin), 1);
        chk("R2 write", 32'(req_write), 1);
        chk("R2 read low", 32'(req_read), 0);
        chk("R2 addr", 32'(req_addr), 32'(a));
        chk("R2 count", 32'(req_burstcount), 4);
        req_ready = 1'b0;
        #1;
        chk("R7 busy not ready", 32'(cmd_ready), 0);
        tick();
        chk("R3 strobe dropped in stall", 32'(req_burstbegin), 0);
        chk("R4 write held", 32'(req_write), 1);
        chk("R4 addr held", 32'(req_addr), 32'(a));
        chk("R4 count held", 32'(req_burstcount), 4);
        req_ready = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            chk("R5 write during beats", 32'(req_write), 1);
            #1;
            chk("R7 ready only on last beat", 32'(cmd_ready), (i == 4) ? 1 : 0);
            tick();
        end
        chk("R5 write ends", 32'(req_write), 0);
        chk("R5 no read", 32'(req_read), 0);
    endtask

    task automatic t_len_zero;
        issue(1'b1, 23'h00_0F00, 4'd0);
        chk("R2 zero len count", 32'(req_burstcount), 1);
        req_ready = 1'b1;
        #1;
        chk("R5 single beat ready", 32'(cmd_ready), 1);
        tick();
        chk("R5 single beat done", 32'(req_write), 0);
    endtask

    task automatic t_read_stall;
        logic [ADDR_W-1:0] a = 23'h7F_FF01;
        issue(1'b0, a, 4'd8);
        chk("R2 read strobe", 32'(req_burstbegin), 1);
        chk("R2 read req", 32'(req_read), 1);
        chk("R2 read count", 32'(req_burstcount), 8);
        req_ready = 1'b0;
        tick();
        chk("R3 read strobe single", 32'(req_burstbegin), 0);
        chk("R4 read held", 32'(req_read), 1);
        chk("R4 read addr held", 32'(req_addr), 32'(a));
        tick();
        chk("R4 read still held", 32'(req_read), 1);
        req_ready = 1'b1;
        #1;
        chk("R7 read accept frees", 32'(cmd_ready), 1);
        tick();
        chk("R6 read drops", 32'(req_read), 0);
    endtask

    task automatic t_queued;
        logic [ADDR_W-1:0] b = 23'h2A_5A5A;
        req_ready = 1'b0;
        issue(1'b1, 23'h01_0000, 4'd2);
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        cmd_addr  = b;
        cmd_len   = 4'd1;
        tick();
        chk("R7 no take in stall", 32'(req_burstbegin), 0);
        chk("R7 write still going", 32'(req_write), 1);
        req_ready = 1'b1;
        tick();
        chk("R7 no take mid burst", 32'(req_burstbegin), 0);
        chk("R7 addr unchanged", 32'(req_addr), 32'h01_0000);
        tick();
        chk("R7 back to back strobe", 32'(req_burstbegin), 1);
        chk("R7 back to back read", 32'(req_read), 1);
        chk("R7 back to back addr", 32'(req_addr), 32'(b));
        cmd_valid = 1'b0;
        tick();
        chk("R6 queued read done", 32'(req_read), 0);
    endtask

    task automatic t_split;
        logic [ADDR_W-1:0] a = 23'h5A_BCDE;
        issue(1'b0, a, 4'd1);
        chk("R8 row", 32'(mon_row), 32'(a) >> 10);
        chk("R8 bank", 32'(mon_bank), (32'(a) >> 8) & 32'h3);
        chk("R8 col", 32'(mon_col), (32'(a) & 32'hFF) << 2);
        req_ready = 1'b1;
        tick();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_write_stall();
        t_len_zero();
        t_read_stall();
        t_queued();
        t_split();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule